// File: doc/BRIEF.md
# Byte-Wide Command/Response FIFO Register Block

This block is the device side of a small memory-mapped command interface for a security coprocessor. It serves one requester. The host reaches it through byte-wide reads and writes at fixed offsets. An ownership register grants the interface to the host and takes it back. A status register steps through a handshake: ready for a command, command still incomplete, execute, response waiting. A burst-count field tells the host how many data-port bytes it may move without polling again. One data port accepts the command bytes and returns the response bytes.

Command bytes go into an internal byte buffer. The command length comes from the four-byte big-endian size field that starts at byte 2 of the command. When the host asks for execution, a stub executor writes a fixed 10-byte success header into the same buffer. After a fixed latency it offers that header for readback. The header can be replayed from its first byte on request, and execution can be cancelled while it is running.

Top module: `tpmfifo_regs`

## Requirements
- R1: Offset 0x00 (ownership register) reads bit7=1, bit0=1 and bit5 = 1 while the interface is owned; all other bits read 0. Writing bit1 while not owned grants ownership. Writing bit5 while owned releases ownership, abandons any command or response, and returns to idle.
- R2: While not owned, reads of offsets 0x18, 0x19, 0x1A, 0x1B and 0x24 return 0xFF, and writes to them have no effect.
- R3: Offset 0x18 (status) reads bit7=1 always, bit6 = ready, bit4 = response available, bit3 = expecting more bytes, and all other bits 0. Writing bit6 outside execution starts a new command with an empty buffer. Ready reads 1 only until the first command byte arrives.
- R4: While receiving, bit3 stays 1 until at least 6 bytes have been written and the byte count has reached the big-endian size held in command bytes 2..5. Data-port writes made while bit3 is 0 are dropped.
- R5: A status write with bit5 (execute) is accepted only while receiving with bit3 = 0. Otherwise it is ignored.
- R6: EXEC_LAT clock edges after the edge that accepts execute, bit4 reads 1. Data-port reads at 0x24 then return 80 01 00 00 00 0A 00 00 00 00 in that order, one byte per read. After the last byte, bit4 reads 0 and the data port reads 0x00.
- R7: In the response phase, a status write with bit1 (retry) makes the next data-port read return the first response byte again.
- R8: Burst count is at 0x19 (low byte) and 0x1A (high byte). While expecting bytes it reads min(BURST_MAX, DEPTH - bytes held). While a response is available it reads min(BURST_MAX, response bytes left). Otherwise it reads 0.
- R9: Writing bit0 of 0x1B during execution cancels it and returns to idle with no response. Status bit6 writes during execution are ignored.
- R10: After reset the interface is not owned and idle. Offsets without a register read 0x00.
- R11: Once DEPTH bytes are held, further data-port writes are dropped and burst count reads 0, even if the size field asks for more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; a read of 0x24 consumes a byte |
| addr | input | 12 | Byte offset in the register window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid in the same cycle |

## Verification
The hardest state to reach from the ports is a full buffer while the interface is still expecting bytes. This requires a size field larger than the buffer. The bench builds the block with a 32-byte buffer and sends a command that declares 100 bytes, so burst count reaches 0 with expect still set. Two other cases need precise timing: a cancel that lands during the execution window, and a size field smaller than the header, where expect must still wait for six bytes. The bench polls status on every idle cycle, so the exact cycle of every phase change is compared against the behavioural model.

// File: rtl/tpmfifo_pkg.sv
package tpmfifo_pkg;
    localparam logic [11:0] OFF_OWN   = 12'h000;
    localparam logic [11:0] OFF_STS   = 12'h018;
    localparam logic [11:0] OFF_BLO   = 12'h019;
    localparam logic [11:0] OFF_BHI   = 12'h01A;
    localparam logic [11:0] OFF_CAN   = 12'h01B;
    localparam logic [11:0] OFF_DATA  = 12'h024;

    localparam int HDR_LEN = 6;   // bytes needed before the size field is complete
    localparam int RSP_LEN = 10;  // stub response length

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_EXEC = 2'd2,
        PH_RESP = 2'd3
    } phase_e;

    // Fixed success header produced by the stub executor
    function automatic logic [7:0] stub_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h80;
            4'd1:    return 8'h01;
            4'd5:    return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/tpmfifo_buf.sv
module tpmfifo_buf #(
    parameter int DEPTH = 1280,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tpmfifo_exec.sv
module tpmfifo_exec #(
    parameter int LAT = 16,
    localparam int TW = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    output logic          busy,
    output logic [TW-1:0] idx,
    output logic          done
);
    logic          run_d, run_q;
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        run_d = run_q;
        cnt_d = cnt_q;
        if (abort) begin
            run_d = 1'b0;
        end else if (start) begin
            run_d = 1'b1;
            cnt_d = '0;
        end else if (run_q) begin
            if (cnt_q == TW'(LAT - 1)) run_d = 1'b0;
            else                       cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end

    assign busy = run_q;
    assign idx  = cnt_q;
    assign done = run_q && (cnt_q == TW'(LAT - 1)) && !abort;
endmodule

// File: rtl/tpmfifo_regs.sv
module tpmfifo_regs
    import tpmfifo_pkg::*;
#(
    parameter int DEPTH     = 1280,
    parameter int BURST_MAX = 8,
    parameter int EXEC_LAT  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [11:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int AW  = $clog2(DEPTH);
    localparam int LAT = (EXEC_LAT < RSP_LEN) ? RSP_LEN : EXEC_LAT;
    localparam int TW  = $clog2(LAT + 1);

    typedef struct packed {
        logic          owner;
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [31:0]   len;
        logic [3:0]    rptr;
    } st_t;

    st_t st_d, st_q;

    logic          ex_start, ex_abort, ex_busy, ex_done;
    logic [TW-1:0] ex_idx;
    logic          buf_we;
    logic [AW-1:0] buf_wa;
    logic [7:0]    buf_wd, buf_rd;
    logic          exp_w, rdy_w, avail_w;
    logic [15:0]   burst;
    logic [31:0]   room;

    wire wr_own  = wr_en && (addr == OFF_OWN);
    wire wr_sts  = wr_en && (addr == OFF_STS);
    wire wr_can  = wr_en && (addr == OFF_CAN);
    wire wr_data = wr_en && (addr == OFF_DATA);
    wire rd_data = rd_en && (addr == OFF_DATA);

    assign exp_w   = (st_q.phase == PH_RECV) &&
                     ((st_q.cnt < CW'(HDR_LEN)) || (32'(st_q.cnt) < st_q.len));
    assign rdy_w   = (st_q.phase == PH_RECV) && (st_q.cnt == '0);
    assign avail_w = (st_q.phase == PH_RESP) && (st_q.rptr < 4'(RSP_LEN));

    always_comb begin
        burst = '0;
        room  = '0;
        if (exp_w) begin
            room  = 32'(DEPTH) - 32'(st_q.cnt);
            burst = 16'((room > 32'(BURST_MAX)) ? 32'(BURST_MAX) : room);
        end else if (avail_w) begin
            room  = 32'(RSP_LEN) - 32'(st_q.rptr);
            burst = 16'((room > 32'(BURST_MAX)) ? 32'(BURST_MAX) : room);
        end
    end

    always_comb begin
        st_d     = st_q;
        ex_start = 1'b0;
        ex_abort = 1'b0;
        buf_we   = 1'b0;
        buf_wa   = '0;
        buf_wd   = '0;
        if (wr_own) begin
            if (st_q.owner && wdata[5]) begin
                st_d.owner = 1'b0;
                st_d.phase = PH_IDLE;
                ex_abort   = 1'b1;
            end else if (!st_q.owner && wdata[1]) begin
                st_d.owner = 1'b1;
            end
        end else if (st_q.owner) begin
            if (wr_sts) begin
                if (wdata[6] && st_q.phase != PH_EXEC) begin
                    st_d.phase = PH_RECV;
                    st_d.cnt   = '0;
                    st_d.len   = '0;
                    st_d.rptr  = '0;
                end else if (wdata[5] && st_q.phase == PH_RECV && !exp_w) begin
                    st_d.phase = PH_EXEC;
                    ex_start   = 1'b1;
                end else if (wdata[1] && st_q.phase == PH_RESP) begin
                    st_d.rptr = '0;
                end
            end
            if (wr_can && wdata[0] && st_q.phase == PH_EXEC) begin
                st_d.phase = PH_IDLE;
                ex_abort   = 1'b1;
            end
            if (wr_data && exp_w && st_q.cnt < CW'(DEPTH)) begin
                buf_we   = 1'b1;
                buf_wa   = AW'(st_q.cnt);
                buf_wd   = wdata;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt >= CW'(2) && st_q.cnt < CW'(HDR_LEN))
                    st_d.len = {st_q.len[23:0], wdata};
            end
            if (rd_data && avail_w) st_d.rptr = st_q.rptr + 1'b1;
        end
        // stub executor fills the response header into the buffer
        if (st_q.phase == PH_EXEC && ex_busy && ex_idx < TW'(RSP_LEN)) begin
            buf_we = 1'b1;
            buf_wa = AW'(ex_idx);
            buf_wd = stub_byte(4'(ex_idx));
        end
        if (ex_done && st_d.phase == PH_EXEC) begin
            st_d.phase = PH_RESP;
            st_d.rptr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: 1'b0, phase: PH_IDLE, cnt: '0, len: '0, rptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            OFF_OWN:  rdata = {1'b1, 1'b0, st_q.owner, 4'b0000, 1'b1};
            OFF_STS:  rdata = st_q.owner ? {1'b1, rdy_w, 1'b0, avail_w, exp_w, 3'b000} : 8'hFF;
            OFF_BLO:  rdata = st_q.owner ? burst[7:0]  : 8'hFF;
            OFF_BHI:  rdata = st_q.owner ? burst[15:8] : 8'hFF;
            OFF_CAN:  rdata = st_q.owner ? 8'h00 : 8'hFF;
            OFF_DATA: rdata = st_q.owner ? (avail_w ? buf_rd : 8'h00) : 8'hFF;
            default:  rdata = 8'h00;
        endcase
    end

    tpmfifo_buf #(.DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_wa),
        .wdata (buf_wd),
        .raddr (AW'(st_q.rptr)),
        .rdata (buf_rd)
    );

    tpmfifo_exec #(.LAT(LAT)) u_exec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ex_start),
        .abort (ex_abort),
        .busy  (ex_busy),
        .idx   (ex_idx),
        .done  (ex_done)
    );
endmodule

// File: rtl/tpmfifo_regs_chk.sv
module tpmfifo_regs_chk
    import tpmfifo_pkg::*;
#(
    parameter int DEPTH = 1280,
    parameter int CW    = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [11:0]   addr,
    input logic [7:0]    wdata,
    input logic          owner,
    input phase_e        phase,
    input logic [CW-1:0] cnt,
    input logic [3:0]    rptr,
    input logic          exp_w
);
    wire sts_wr = owner && wr_en && (addr == OFF_STS);

    AST_REQ_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_OWN && wdata[1] && !owner) |=> owner); // R1

    AST_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !owner |-> phase == PH_IDLE); // R2

    AST_READY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && wdata[6] && phase != PH_EXEC) |=> (phase == PH_RECV && cnt == '0)); // R3

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && $past(phase) == PH_EXEC) |-> $stable(cnt)); // R4

    AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !wdata[6] && wdata[5] && phase == PH_RECV && !exp_w) |=> phase == PH_EXEC); // R5

    AST_RESP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESP && $past(phase) != PH_RESP) |-> $past(phase) == PH_EXEC); // R6

    AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && phase == PH_RESP && wdata[1] && !wdata[6]) |=> rptr == '0); // R7

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R11
endmodule

bind tpmfifo_regs tpmfifo_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .owner (st_q.owner),
    .phase (st_q.phase),
    .cnt   (st_q.cnt),
    .rptr  (st_q.rptr),
    .exp_w (exp_w)
);

// File: tb/tpmfifo_regs_bench.sv
`timescale 1ns/1ps
module tpmfifo_regs_bench;
    localparam int DEPTH = 32;
    localparam int BMAX  = 8;
    localparam int LAT   = 12;

    localparam logic [11:0] A_OWN = 12'h000, A_STS = 12'h018, A_BLO = 12'h019,
                            A_BHI = 12'h01A, A_CAN = 12'h01B, A_DAT = 12'h024,
                            A_GAP = 12'h008;
    localparam int S_IDLE = 0, S_RECV = 1, S_EXEC = 2, S_RESP = 3;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    always #4 clk = ~clk;

    tpmfifo_regs #(.DEPTH(DEPTH), .BURST_MAX(BMAX), .EXEC_LAT(LAT)) u_tpmfifo_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference state
    bit          m_own;
    int          m_ph, m_cnt, m_rptr, m_exec;
    logic [31:0] m_len;
    logic [7:0]  m_rsp [10] = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00};

    function automatic bit m_expect();
        return (m_ph == S_RECV) && ((m_cnt < 6) || (longint'(m_cnt) < longint'(m_len)));
    endfunction

    function automatic int m_burst();
        int r;
        if (m_expect()) r = DEPTH - m_cnt;
        else if (m_ph == S_RESP && m_rptr < 10) r = 10 - m_rptr;
        else return 0;
        return (r > BMAX) ? BMAX : r;
    endfunction

    function automatic logic [7:0] m_read(input logic [11:0] a);
        int b;
        b = m_burst();
        if (a == A_OWN) return 8'h81 | (m_own ? 8'h20 : 8'h00);
        if (a == A_STS || a == A_BLO || a == A_BHI || a == A_CAN || a == A_DAT) begin
            if (!m_own) return 8'hFF;
            case (a)
                A_STS: return 8'h80 | ((m_ph == S_RECV && m_cnt == 0) ? 8'h40 : 8'h00)
                             | ((m_ph == S_RESP && m_rptr < 10) ? 8'h10 : 8'h00)
                             | (m_expect() ? 8'h08 : 8'h00);
                A_BLO: return 8'(b);
                A_BHI: return 8'(b >> 8);
                A_DAT: return (m_ph == S_RESP && m_rptr < 10) ? m_rsp[m_rptr] : 8'h00;
                default: return 8'h00;
            endcase
        end
        return 8'h00;
    endfunction

    task automatic m_step(input bit we, input bit re, input logic [11:0] a, input logic [7:0] d);
        bit was_exec, ex;
        was_exec = (m_ph == S_EXEC);
        ex = m_expect();
        if (we && a == A_OWN) begin
            if (m_own && d[5]) begin m_own = 0; m_ph = S_IDLE; end
            else if (!m_own && d[1]) m_own = 1;
        end else if (m_own) begin
            if (we && a == A_STS) begin
                if (d[6] && m_ph != S_EXEC) begin
                    m_ph = S_RECV; m_cnt = 0; m_len = '0; m_rptr = 0;
                end else if (d[5] && m_ph == S_RECV && !ex) begin
                    m_ph = S_EXEC; m_exec = LAT;
                end else if (d[1] && m_ph == S_RESP) m_rptr = 0;
            end
            if (we && a == A_CAN && d[0] && m_ph == S_EXEC) m_ph = S_IDLE;
            if (we && a == A_DAT && ex && m_cnt < DEPTH) begin
                if (m_cnt >= 2 && m_cnt <= 5) m_len = {m_len[23:0], d};
                m_cnt++;
            end
            if (re && a == A_DAT && m_ph == S_RESP && m_rptr < 10) m_rptr++;
        end
        if (was_exec && m_ph == S_EXEC) begin
            m_exec--;
            if (m_exec == 0) begin m_ph = S_RESP; m_rptr = 0; end
        end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic op(input bit we, input bit re, input logic [11:0] a,
                      input logic [7:0] d, input string req);
        @(negedge clk);
        wr_en = we; rd_en = re; addr = a; wdata = d;
        #1;
        if (re) check(req, rdata, m_read(a));
        @(posedge clk);
        m_step(we, re, a, d);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input string req);
        op(1'b1, 1'b0, a, d, req);
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        op(1'b0, 1'b1, a, 8'h00, req);
    endtask

    task automatic poll(input int n, input string req);
        for (int i = 0; i < n; i++) rd(A_STS, req);
    endtask

    task automatic send(input logic [7:0] b [$], input string req);
        foreach (b[i]) begin
            wr(A_DAT, b[i], req);
            rd(A_STS, req);
            rd(A_BLO, req);
        end
    endtask

    initial begin
        m_own = 0; m_ph = S_IDLE; m_cnt = 0; m_rptr = 0; m_exec = 0; m_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state and unmapped offset
        rd(A_OWN, "R10");
        rd(A_GAP, "R10");
        // R2: locked out before ownership
        rd(A_STS, "R2");
        rd(A_DAT, "R2");
        wr(A_STS, 8'h40, "R2");
        wr(A_DAT, 8'h55, "R2");
        rd(A_BLO, "R2");
        // R1: grant
        wr(A_OWN, 8'h02, "R1");
        rd(A_OWN, "R1");
        rd(A_STS, "R2");
        // R3: enter ready
        wr(A_STS, 8'h40, "R3");
        rd(A_STS, "R3");
        rd(A_BLO, "R8");
        rd(A_BHI, "R8");
        // R5: go too early is ignored
        wr(A_STS, 8'h20, "R5");
        rd(A_STS, "R5");
        // R4: 12-byte command
        send('{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0C,
               8'h00, 8'h00, 8'h01, 8'h44, 8'h00, 8'h00}, "R4");
        wr(A_DAT, 8'hEE, "R4");
        rd(A_STS, "R4");
        rd(A_BLO, "R8");
        // R5/R6: execute, R9: ready ignored mid-run
        wr(A_STS, 8'h20, "R5");
        poll(3, "R6");
        wr(A_STS, 8'h40, "R9");
        poll(LAT, "R6");
        rd(A_BLO, "R8");
        for (int i = 0; i < 10; i++) begin
            rd(A_DAT, "R6");
            rd(A_BLO, "R8");
        end
        rd(A_STS, "R6");
        rd(A_DAT, "R6");
        // R7: retry
        wr(A_STS, 8'h02, "R7");
        rd(A_STS, "R7");
        rd(A_DAT, "R7");
        rd(A_DAT, "R7");
        // R11: size beyond capacity
        wr(A_STS, 8'h40, "R3");
        send('{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h64}, "R11");
        for (int i = 0; i < DEPTH - 6 + 3; i++) begin
            wr(A_DAT, 8'(i), "R11");
            rd(A_BLO, "R11");
        end
        rd(A_STS, "R11");
        rd(A_BHI, "R11");
        // R4: size below header length
        wr(A_STS, 8'h40, "R4");
        send('{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02}, "R4");
        // R9: cancel during execution
        wr(A_STS, 8'h20, "R5");
        poll(4, "R9");
        wr(A_CAN, 8'h01, "R9");
        poll(LAT + 2, "R9");
        rd(A_DAT, "R9");
        // R1: release mid-response
        wr(A_STS, 8'h40, "R3");
        send('{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h06}, "R4");
        wr(A_STS, 8'h20, "R5");
        poll(LAT + 1, "R6");
        wr(A_OWN, 8'h20, "R1");
        rd(A_OWN, "R1");
        rd(A_STS, "R2");
        rd(A_DAT, "R2");
        wr(A_OWN, 8'h02, "R1");
        rd(A_STS, "R1");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule